// File: doc/BRIEF.md
# Offset and Gain Trim Unit

This block corrects unsigned 12-bit conversion results with two programmable trim codes, one for offset and one for gain. Each code is 14 bits wide and centred on mid-scale (0x2000), so the reset values give an exact pass-through. Codes above mid-scale add a positive offset or a gain above one. Codes below mid-scale do the reverse.

The offset code spans plus or minus 5 % of full scale, in steps of 1/8192 of that span. The gain code spans a factor of 0.975 to 1.025, in steps of 1/327680. Each sample first gets the rounded offset term. The result is then multiplied by the gain factor, rounded, and clamped to the 12-bit range.

Software sets the codes through a small register port. Each code sits in a 16-bit word whose two top bits are always zero. A registered read port returns the words. Samples stream in with a valid flag, one per clock if needed, and come out two clocks later.

Top module: `trim_unit`

## Requirements
- R1: After reset both trim words read back as 0x2000 and `out_valid` is low.
- R2: A write with `wr_addr` 0 loads the offset word and with `wr_addr` 1 loads the gain word. `rd_data` shows the word selected by `rd_addr` one clock after that address is sampled.
- R3: Bits 15:14 of `wr_data` are discarded, and bits 15:14 of `rd_data` always read zero.
- R4: Writes to addresses 2 and 3 change no trim word, and reads of those addresses return zero.
- R5: With offset code c and sample x, the intermediate value is x + round((c - 8192) * 4095 / 163840). Rounding is to nearest, with halves going up.
- R6: With gain code g and intermediate value v, the output is round(v * (327680 + g - 8192) / 327680). Rounding is to nearest, with halves going up.
- R7: The result of R6 is clamped to 0 when negative and to 4095 when above 4095.
- R8: `out_valid` is high exactly two clocks after a clock on which `in_valid` was high, and at no other time.
- R9: `out_data` holds its last value while `out_valid` is low.
- R10: With both codes at 0x2000, every sample passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 offset, 1 gain |
| wr_data | input | 16 | Write data; bits 13:0 are the code |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 12 | Unsigned input sample |
| out_valid | output | 1 | Corrected sample valid |
| out_data | output | 12 | Corrected, clamped sample |

## Verification
A wrong stored trim code appears in `rd_data` one clock after the read address is set. It also appears as a systematic error on every sample that leaves the pipeline two clocks later. A rounding or bias error in either stage shows up as an off-by-one on a subset of samples, so the whole 12-bit input range is swept for each of several code pairs. These pairs include both extreme codes, mid-scale, and codes just off mid-scale. A pipeline valid or hold error shows at the ports as a missing, extra or early `out_valid`, or as `out_data` changing while `out_valid` is low.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int ADDR_OFFSET = 0;
  localparam int ADDR_GAIN   = 1;
  localparam int NUM_TRIMS   = 2;
endpackage

// File: rtl/trim_regs.sv
module trim_regs #(
  parameter int CODE_W = 14,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [CODE_W-1:0] off_code,
  output logic [CODE_W-1:0] gain_code
);
  import trim_pkg::*;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam int PAD_W = REG_W - CODE_W;

  logic [CODE_W-1:0] code_q [NUM_TRIMS];
  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[REG_W-1:CODE_W];

  for (genvar i = 0; i < NUM_TRIMS; i++) begin : g_trim
    always_ff @(posedge clk) begin
      if (rst)
        code_q[i] <= MID;
      else if (wr_en && wr_addr == ADDR_W'(i))
        code_q[i] <= wr_data[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr < ADDR_W'(NUM_TRIMS))
      rd_data <= {{PAD_W{1'b0}}, code_q[rd_addr]};
    else
      rd_data <= '0;
  end

  assign off_code  = code_q[ADDR_OFFSET];
  assign gain_code = code_q[ADDR_GAIN];
endmodule

// File: rtl/trim_offset_stage.sv
module trim_offset_stage #(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [SAMPLE_W-1:0]   in_data,
  input  logic [CODE_W-1:0]     off_code,
  output logic                  mid_valid,
  output logic [SAMPLE_W+1:0]   mid_data
);
  localparam int ACC_W = SAMPLE_W + CODE_W + 10;
  localparam int S1_W  = SAMPLE_W + 2;
  localparam longint MID  = longint'(1) << (CODE_W - 1);
  localparam longint FS   = (longint'(1) << SAMPLE_W) - 1;
  localparam int SH       = CODE_W + 1;          // step divisor = 5 << SH
  localparam longint BIAS = FS / 16 + 4;
  localparam logic [ACC_W-1:0] K_ADD = ACC_W'(BIAS * 20 * MID + 10 * MID);
  localparam logic [ACC_W-1:0] FIVE  = ACC_W'(5);

  logic [ACC_W-1:0] delta, num, quo, off, sum;

  always_comb begin
    delta = ACC_W'(off_code) - ACC_W'(MID);
    num   = delta * ACC_W'(FS) + K_ADD;
    quo   = (num >> SH) / FIVE;
    off   = quo - ACC_W'(BIAS);
    sum   = ACC_W'(in_data) + off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_valid <= 1'b0;
      mid_data  <= '0;
    end else begin
      mid_valid <= in_valid;
      if (in_valid)
        mid_data <= sum[S1_W-1:0];
    end
  end
endmodule

// File: rtl/trim_gain_stage.sv
module trim_gain_stage #(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mid_valid,
  input  logic [SAMPLE_W+1:0]   mid_data,
  input  logic [CODE_W-1:0]     gain_code,
  output logic                  out_valid,
  output logic [SAMPLE_W-1:0]   out_data
);
  localparam int ACC_W = SAMPLE_W + CODE_W + 10;
  localparam int S1_W  = SAMPLE_W + 2;
  localparam longint MID  = longint'(1) << (CODE_W - 1);
  localparam longint FS   = (longint'(1) << SAMPLE_W) - 1;
  localparam int SH       = CODE_W + 2;          // unity divisor = 5 << SH
  localparam longint BIAS = FS / 16 + 4;
  localparam logic [ACC_W-1:0] UNITY = ACC_W'(40 * MID);
  localparam logic [ACC_W-1:0] K_ADD = ACC_W'(BIAS * 40 * MID + 20 * MID);
  localparam logic [ACC_W-1:0] FIVE  = ACC_W'(5);
  localparam logic [ACC_W-1:0] TOP   = ACC_W'(FS);

  logic [ACC_W-1:0] v_ext, factor, num, quo, res;
  logic [SAMPLE_W-1:0] clamped;

  always_comb begin
    v_ext  = {{(ACC_W-S1_W){mid_data[S1_W-1]}}, mid_data};
    factor = UNITY + ACC_W'(gain_code) - ACC_W'(MID);
    num    = v_ext * factor + K_ADD;
    quo    = (num >> SH) / FIVE;
    res    = quo - ACC_W'(BIAS);
    if (res[ACC_W-1])
      clamped = '0;
    else if (res > TOP)
      clamped = TOP[SAMPLE_W-1:0];
    else
      clamped = res[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= mid_valid;
      if (mid_valid)
        out_data <= clamped;
    end
  end
endmodule

// File: rtl/trim_unit.sv
module trim_unit #(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 14,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data
);
  logic [CODE_W-1:0]   off_code, gain_code;
  logic                mid_valid;
  logic [SAMPLE_W+1:0] mid_data;

  trim_regs #(.CODE_W(CODE_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .off_code(off_code), .gain_code(gain_code)
  );

  trim_offset_stage #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_off (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .off_code(off_code), .mid_valid(mid_valid), .mid_data(mid_data)
  );

  trim_gain_stage #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_gain (
    .clk(clk), .rst(rst), .mid_valid(mid_valid), .mid_data(mid_data),
    .gain_code(gain_code), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/trim_unit_chk.sv
module trim_unit_chk #(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 14,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [REG_W-1:0]    wr_data,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_data,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_data,
  input logic [CODE_W-1:0]   off_code,
  input logic [CODE_W-1:0]   gain_code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  p_offset_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(0)) |=> off_code == $past(wr_data[CODE_W-1:0]));

  p_gain_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(1)) |=> gain_code == $past(wr_data[CODE_W-1:0]));

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  p_identity_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(off_code, 2) == MID && $past(gain_code, 1) == MID)
      |-> out_data == $past(in_data, 2));
endmodule

bind trim_unit trim_unit_chk #(
  .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
  .out_data(out_data), .off_code(off_code), .gain_code(gain_code)
);

// File: tb/trim_unit_test.sv
module trim_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        out_valid;
  logic [11:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_q[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  trim_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint fdiv(longint a, longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  // Expected output from R5, R6, R7
  function automatic int model(int x, int oc, int gc);
    longint d, dg, v, n, y;
    d  = longint'(oc) - 8192;
    dg = longint'(gc) - 8192;
    v  = longint'(x) + fdiv(2 * d * 4095 + 163840, 327680);
    n  = v * (327680 + dg);
    y  = fdiv(2 * n + 327680, 655360);
    if (y < 0) y = 0;
    if (y > 4095) y = 4095;
    return int'(y);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // Output monitor: compares every valid output against the queue
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected out_valid", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(t, out_data, e);
      end
    end
  end

  task automatic reg_write(int addr, int data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_read(int addr, output int val);
    @(posedge clk); #1;
    rd_addr = 2'(addr);
    @(posedge clk);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic sweep(int oc, int gc, string tag);
    int rv;
    reg_write(0, oc);
    reg_write(1, gc);
    reg_read(0, rv); check({tag, " R2 offset readback"}, rv, oc);
    reg_read(1, rv); check({tag, " R2 gain readback"}, rv, gc);
    @(posedge clk); #1;
    for (int x = 0; x < 4096; x++) begin
      in_valid = 1'b1;
      in_data  = 12'(x);
      exp_q.push_back(model(x, oc, gc));
      exp_tag.push_back(tag);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (4) @(posedge clk);
    check({tag, " R8 all outputs seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int rv;
    logic [11:0] held;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 out_valid after reset", out_valid, 0);
    reg_read(0, rv); check("R1 offset reset value", rv, 16'h2000);
    reg_read(1, rv); check("R1 gain reset value", rv, 16'h2000);

    // R3: top bits discarded
    reg_write(0, 16'hC123);
    reg_read(0, rv); check("R3 offset top bits zero", rv, 16'h0123);
    reg_write(1, 16'h7FFF);
    reg_read(1, rv); check("R3 gain top bits zero", rv, 16'h3FFF);

    // R4: unmapped addresses
    reg_write(0, 16'h2000);
    reg_write(1, 16'h2000);
    reg_write(2, 16'h1111);
    reg_write(3, 16'h0555);
    reg_read(0, rv); check("R4 offset untouched", rv, 16'h2000);
    reg_read(1, rv); check("R4 gain untouched", rv, 16'h2000);
    reg_read(2, rv); check("R4 addr 2 reads zero", rv, 0);
    reg_read(3, rv); check("R4 addr 3 reads zero", rv, 0);

    // R8: exact latency of a single pulse; R9 hold
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 12'd1234;
    exp_q.push_back(1234); exp_tag.push_back("R10 pulse identity");
    @(negedge clk); check("R8 not valid at 0 clocks", out_valid, 0);
    @(posedge clk); #1; in_valid = 1'b0; in_data = 12'd77;
    @(negedge clk); check("R8 not valid at 1 clock", out_valid, 0);
    @(negedge clk); check("R8 valid at 2 clocks", out_valid, 1);
    held = out_data;
    @(negedge clk); check("R8 valid drops", out_valid, 0);
    repeat (3) @(negedge clk);
    check("R9 out_data held", out_data, held);

    // Sweeps over full input range
    sweep(16'h2000, 16'h2000, "R10 identity");
    sweep(16'h0000, 16'h2000, "R5 R7 min offset");
    sweep(16'h3FFF, 16'h2000, "R5 R7 max offset");
    sweep(16'h2005, 16'h2000, "R5 offset rounding");
    sweep(16'h1FFB, 16'h2000, "R5 negative offset rounding");
    sweep(16'h2000, 16'h0000, "R6 min gain");
    sweep(16'h2000, 16'h3FFF, "R6 R7 max gain");
    sweep(16'h2000, 16'h2001, "R6 gain rounding");
    sweep(16'h0000, 16'h0000, "R6 R7 both min");
    sweep(16'h3FFF, 16'h3FFF, "R6 R7 both max");
    sweep(16'h1234, 16'h2ABC, "R5 R6 mixed");

    // R7 spot checks with hand values
    check("R7 clamp high spot", model(4095, 16'h3FFF, 16'h3FFF), 4095);
    check("R7 clamp low spot", model(0, 16'h0000, 16'h2000), 0);
    summary();
  end
endmodule